// File: doc/BRIEF.md
# Comparator Event Timer Channel

This block is a single event channel that watches a shared free-running 64-bit tick count. It raises a one-cycle expiry pulse when that count reaches a programmable comparator. The channel runs in one of two modes. In one-shot mode it fires once and then stays quiet. In periodic mode it reloads itself by adding a hidden period register to the comparator after every expiry. A narrow mode restricts the comparison and the reload arithmetic to the low 32 bits of the count. In narrow one-shot operation the channel also fires an early event when the low 32 bits of the count roll over, if the roll-over comes before the match.

Software programs the channel through three plain write strobes: one for the control word and one for each 32-bit half of the comparator word. A comparator write is steered either to the comparator, to the hidden period, or to both. The steering depends on the mode and on a one-shot "load comparator" control bit. The comparator and the control word can be read back at any time.

Interrupt routing, bus decode and the counter itself sit outside the block. All pins are plain control or status pins, and none carry a stream, so there is no back-pressure.

Top module: `evt_tmr_chan`

## Requirements
- R1: After reset the comparator reads all ones, the hidden period is 0, the channel is disarmed and `cfg_rd_o` reads 0x30. Bit 4 (periodic capable) and bit 5 (64-bit capable) are constant ones. Bit 0 (enable), bit 1 (periodic), bit 2 (load comparator) and bit 3 (narrow) are zero.
- R2: In one-shot mode an armed channel evaluates the count in cycle k and finds the comparator not ahead of it. It then drives `expire_o` high for exactly cycle k+1 and disarms, so no further pulse follows.
- R3: "Comparator ahead" means that the signed difference comparator minus count is greater than zero. The difference is 32 bits wide in narrow mode, where the upper count bits are ignored, and 64 bits wide otherwise.
- R4: In periodic mode with a nonzero period, each expiry adds the period to the comparator in the cycle after evaluation. One pulse is produced per period.
- R5: If the comparator is still not ahead after a reload, the period is added again on every following cycle until it is ahead. No further pulse is produced during this catch-up.
- R6: A write to either comparator half updates that half of the comparator in one-shot mode, or in periodic mode when bit 2 is 1. Otherwise the comparator is unchanged. Every comparator write clears bit 2.
- R7: In periodic mode a comparator-half write also loads the same half of the period. In narrow mode the loaded value has bit 31 cleared. In wide mode period bit 63 is always cleared.
- R8: Writing the control word with bit 3 set clears the upper 32 bits of the comparator and of the period. While narrow, writes to the upper comparator half change neither register.
- R9: In narrow mode the periodic reload sum wraps modulo 2^32, and the upper comparator bits stay zero.
- R10: In narrow one-shot mode, if at arming the distance to the match exceeds the distance to the low-half roll-over, the channel pulses when the low 32 bits of the count wrap. It then pulses again at the real match.
- R11: The channel arms on an enable 0-to-1 control write while `cnt_en_i` is 1, on a comparator write while enabled and counting, or on a rising `cnt_en_i` while enabled. Arming happens one cycle later, produces no pulse in that cycle, and recomputes the wrap flag, so a stale pending wrap is dropped.
- R12: An enable 1-to-0 control write, or `cnt_en_i` low, disarms the channel or suppresses evaluation. No pulse follows such a cycle.
- R13: In periodic mode with a zero period, the channel fires once like one-shot mode and disarms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | 64 | Current value of the shared tick counter |
| cnt_en_i | input | 1 | Shared counter is running |
| cfg_wr_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 4 | Control write data: bit0 enable, bit1 periodic, bit2 load comparator, bit3 narrow |
| cmp_lo_wr_i | input | 1 | Lower comparator-half write strobe |
| cmp_hi_wr_i | input | 1 | Upper comparator-half write strobe |
| cmp_wdata_i | input | 32 | Comparator-half write data |
| expire_o | output | 1 | One-cycle expiry pulse |
| cmp_rd_o | output | 64 | Comparator readback |
| cfg_rd_o | output | 6 | Control readback, bits 5:4 constant capability ones |

## Verification
The hidden period and the wrap flag cannot be read directly. A wrong period therefore shows up only at the second expiry of a periodic sequence: as a pulse at the wrong count, and as a comparator readback that moves by the wrong step. A wrong wrap flag shows up as an extra or missing pulse at the low-half roll-over, up to 2^32 ticks after arming. A broken catch-up shows up within a few cycles as a burst of extra pulses. A lost arm or disarm is visible one cycle after the evaluation cycle where a pulse should, or should not, appear.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;
  localparam int CFG_WR_W = 4;
  localparam int CFG_RD_W = 6;
  localparam int B_EN     = 0;
  localparam int B_PER    = 1;
  localparam int B_SET    = 2;
  localparam int B_NAR    = 3;

  typedef struct packed {
    logic narrow;
    logic setval;
    logic periodic;
    logic en;
  } chan_cfg_t;

  function automatic chan_cfg_t cfg_decode(input logic [CFG_WR_W-1:0] w);
    chan_cfg_t c;
    c.en       = w[B_EN];
    c.periodic = w[B_PER];
    c.setval   = w[B_SET];
    c.narrow   = w[B_NAR];
    return c;
  endfunction
endpackage

// File: rtl/evt_tmr_regs.sv
module evt_tmr_regs
  import evt_tmr_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_en_i,
  input  logic                cfg_wr_i,
  input  logic [CFG_WR_W-1:0] cfg_wdata_i,
  input  logic                cmp_lo_wr_i,
  input  logic                cmp_hi_wr_i,
  input  logic [CNT_W/2-1:0]  cmp_wdata_i,
  input  logic                reload_i,
  output chan_cfg_t           cfg_o,
  output logic [CNT_W-1:0]    cmp_o,
  output logic                per_nz_o,
  output logic                arm_req_o,
  output logic                disarm_o
);
  localparam int H = CNT_W / 2;

  chan_cfg_t        cfg_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] per_q;
  logic             cmp_take;
  logic [H-1:0]     lo_per_val;
  logic [H-1:0]     hi_per_val;
  logic [CNT_W-1:0] reload_sum;

  assign cmp_take   = !cfg_q.periodic || cfg_q.setval;
  assign lo_per_val = cfg_q.narrow ? {1'b0, cmp_wdata_i[H-2:0]} : cmp_wdata_i;
  assign hi_per_val = {1'b0, cmp_wdata_i[H-2:0]};

  always_comb begin
    if (cfg_q.narrow) reload_sum = {{H{1'b0}}, cmp_q[H-1:0] + per_q[H-1:0]};
    else              reload_sum = cmp_q + per_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cmp_q <= '1;
      per_q <= '0;
    end else if (cfg_wr_i) begin
      cfg_q <= cfg_decode(cfg_wdata_i);
      if (cfg_wdata_i[B_NAR]) begin
        cmp_q[CNT_W-1:H] <= '0;
        per_q[CNT_W-1:H] <= '0;
      end
    end else if (cmp_lo_wr_i) begin
      if (cmp_take)       cmp_q[H-1:0] <= cmp_wdata_i;
      if (cfg_q.periodic) per_q[H-1:0] <= lo_per_val;
      cfg_q.setval <= 1'b0;
    end else if (cmp_hi_wr_i) begin
      if (!cfg_q.narrow) begin
        if (cmp_take)       cmp_q[CNT_W-1:H] <= cmp_wdata_i;
        if (cfg_q.periodic) per_q[CNT_W-1:H] <= hi_per_val;
      end
      cfg_q.setval <= 1'b0;
    end else if (reload_i) begin
      cmp_q <= reload_sum;
    end
  end

  assign cfg_o     = cfg_q;
  assign cmp_o     = cmp_q;
  assign per_nz_o  = |per_q;
  assign arm_req_o = cnt_en_i &&
                     ((cfg_wr_i && cfg_wdata_i[B_EN] && !cfg_q.en) ||
                      (!cfg_wr_i && (cmp_lo_wr_i || cmp_hi_wr_i) && cfg_q.en));
  assign disarm_o  = cfg_wr_i && cfg_q.en && !cfg_wdata_i[B_EN];

  p_reset_cmp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (cmp_q == '1 && per_q == '0));

  p_setval_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr_i && (cmp_lo_wr_i || cmp_hi_wr_i)) |=> !cfg_q.setval);

  p_period_msb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !per_q[CNT_W-1]);

  p_narrow_hi_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.narrow |-> (cmp_q[CNT_W-1:H] == '0 && per_q[CNT_W-1:H] == '0));

  p_reload_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_i && !cfg_wr_i && !cmp_lo_wr_i && !cmp_hi_wr_i) |=> cmp_q != $past(cmp_q));
endmodule

// File: rtl/evt_tmr_cmp.sv
module evt_tmr_cmp #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             narrow_i,
  output logic             ahead_o,
  output logic             wrap_need_o,
  output logic             wrap_seen_o
);
  localparam int H = CNT_W / 2;

  logic [CNT_W-1:0] diff_w;
  logic [H-1:0]     diff_n;
  logic [H-1:0]     dist_n;
  logic [H-1:0]     room_n;
  logic [H-1:0]     prev_lo_q;

  assign diff_w = cmp_i - cnt_i;
  assign diff_n = cmp_i[H-1:0] - cnt_i[H-1:0];
  assign dist_n = ($signed(diff_n) > 0) ? diff_n : H'(1);
  assign room_n = ~cnt_i[H-1:0];

  assign ahead_o     = narrow_i ? ($signed(diff_n) > 0) : ($signed(diff_w) > 0);
  assign wrap_need_o = room_n < dist_n;
  assign wrap_seen_o = cnt_i[H-1:0] < prev_lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_lo_q <= '0;
    else        prev_lo_q <= cnt_i[H-1:0];
  end

  p_ahead_ne_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ahead_o |-> (cmp_i[H-1:0] != cnt_i[H-1:0] || cmp_i != cnt_i));
endmodule

// File: rtl/evt_tmr_ctl.sv
module evt_tmr_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_en_i,
  input  logic en_i,
  input  logic periodic_i,
  input  logic narrow_i,
  input  logic arm_req_i,
  input  logic disarm_i,
  input  logic ahead_i,
  input  logic wrap_need_i,
  input  logic wrap_seen_i,
  input  logic per_nz_i,
  output logic reload_o,
  output logic expire_o
);
  logic armed_q, wrap_q, behind_q, pend_q, cnt_en_q;
  logic cnt_rise, cnt_fall, kill, arm_go, live;
  logic fire, done, wrap_clr;

  assign cnt_rise = cnt_en_i && !cnt_en_q && en_i;
  assign cnt_fall = !cnt_en_i && cnt_en_q;
  assign kill     = disarm_i || cnt_fall;
  assign arm_go   = (arm_req_i || cnt_rise) && !disarm_i;
  assign live     = armed_q && !pend_q && cnt_en_i && en_i && !disarm_i;

  always_comb begin
    fire     = 1'b0;
    reload_o = 1'b0;
    done     = 1'b0;
    wrap_clr = 1'b0;
    if (live) begin
      if (wrap_q) begin
        if (wrap_seen_i) begin
          fire     = 1'b1;
          wrap_clr = 1'b1;
        end
      end else if (!ahead_i) begin
        if (periodic_i && per_nz_i) begin
          reload_o = 1'b1;
          fire     = !behind_q;
        end else begin
          fire = 1'b1;
          done = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      wrap_q   <= 1'b0;
      behind_q <= 1'b0;
      pend_q   <= 1'b0;
      cnt_en_q <= 1'b0;
      expire_o <= 1'b0;
    end else begin
      cnt_en_q <= cnt_en_i;
      expire_o <= fire;
      pend_q   <= arm_go;
      if (kill) begin
        armed_q  <= 1'b0;
        wrap_q   <= 1'b0;
        behind_q <= 1'b0;
      end else if (pend_q) begin
        armed_q  <= 1'b1;
        wrap_q   <= narrow_i && !periodic_i && wrap_need_i;
        behind_q <= 1'b0;
      end else if (live) begin
        if (wrap_clr) wrap_q <= 1'b0;
        if (done)     armed_q <= 1'b0;
        if (!wrap_q)  behind_q <= reload_o;
      end
    end
  end

  p_stop_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en_i |=> !expire_o);

  p_disarm_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_i |=> !expire_o);

  p_arm_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> !expire_o);

  p_catchup_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_o && behind_q) |=> !expire_o);
endmodule

// File: rtl/evt_tmr_chan.sv
module evt_tmr_chan
  import evt_tmr_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic                cnt_en_i,
  input  logic                cfg_wr_i,
  input  logic [CFG_WR_W-1:0] cfg_wdata_i,
  input  logic                cmp_lo_wr_i,
  input  logic                cmp_hi_wr_i,
  input  logic [CNT_W/2-1:0]  cmp_wdata_i,
  output logic                expire_o,
  output logic [CNT_W-1:0]    cmp_rd_o,
  output logic [CFG_RD_W-1:0] cfg_rd_o
);
  chan_cfg_t        cfg;
  logic [CNT_W-1:0] cmp;
  logic per_nz, arm_req, disarm, reload;
  logic ahead, wrap_need, wrap_seen;

  evt_tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en_i),
    .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i),
    .cmp_lo_wr_i(cmp_lo_wr_i), .cmp_hi_wr_i(cmp_hi_wr_i), .cmp_wdata_i(cmp_wdata_i),
    .reload_i(reload), .cfg_o(cfg), .cmp_o(cmp), .per_nz_o(per_nz),
    .arm_req_o(arm_req), .disarm_o(disarm)
  );

  evt_tmr_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cmp_i(cmp), .narrow_i(cfg.narrow),
    .ahead_o(ahead), .wrap_need_o(wrap_need), .wrap_seen_o(wrap_seen)
  );

  evt_tmr_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en_i), .en_i(cfg.en),
    .periodic_i(cfg.periodic), .narrow_i(cfg.narrow),
    .arm_req_i(arm_req), .disarm_i(disarm), .ahead_i(ahead),
    .wrap_need_i(wrap_need), .wrap_seen_i(wrap_seen), .per_nz_i(per_nz),
    .reload_o(reload), .expire_o(expire_o)
  );

  assign cmp_rd_o = cmp;
  assign cfg_rd_o = {2'b11, cfg.narrow, cfg.setval, cfg.periodic, cfg.en};
endmodule

// File: tb/evt_tmr_chan_test.sv
module evt_tmr_chan_test;
  localparam logic [3:0] EN = 4'd1, PER = 4'd2, SETV = 4'd4, NAR = 4'd8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] ctr = '0;
  logic        run = 1'b0;
  logic        ld = 1'b0;
  logic [63:0] ld_val = '0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_wdata = '0;
  logic        lo_wr = 1'b0, hi_wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        expire;
  logic [63:0] cmp_rd;
  logic [5:0]  cfg_rd;

  int checks = 0, errors = 0, pulses = 0, cyc = 0;
  logic [63:0] last_cnt = '0;

  always #10 clk = ~clk;

  evt_tmr_chan uut (
    .clk(clk), .rst_n(rst_n), .cnt_i(ctr), .cnt_en_i(run),
    .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata),
    .cmp_lo_wr_i(lo_wr), .cmp_hi_wr_i(hi_wr), .cmp_wdata_i(wdata),
    .expire_o(expire), .cmp_rd_o(cmp_rd), .cfg_rd_o(cfg_rd)
  );

  always @(posedge clk) begin
    if (ld) ctr <= ld_val;
    else if (run) ctr <= ctr + 64'd1;
  end

  always @(negedge clk) begin
    if (rst_n && expire) begin
      pulses++;
      last_cnt = ctr;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wcfg(input logic [3:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic wlo(input logic [31:0] v);
    @(negedge clk); lo_wr = 1'b1; wdata = v;
    @(negedge clk); lo_wr = 1'b0;
  endtask

  task automatic whi(input logic [31:0] v);
    @(negedge clk); hi_wr = 1'b1; wdata = v;
    @(negedge clk); hi_wr = 1'b0;
  endtask

  task automatic load(input logic [63:0] v);
    @(negedge clk); ld = 1'b1; ld_val = v;
    @(negedge clk); ld = 1'b0;
  endtask

  task automatic wait_ctr(input logic [63:0] v);
    while (ctr < v) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 cfg readback", {58'd0, cfg_rd}, 64'h30);
    chk("R1 comparator all ones", cmp_rd, '1);
    chk("R1 no pulse", {63'd0, expire}, 64'd0);
  endtask

  task automatic t_oneshot();
    int base;
    run = 1'b1;
    wcfg(4'd0);
    load(64'd100);
    wlo(32'd120); whi(32'd0);
    base = pulses;
    wcfg(EN);
    wait_ctr(64'd170);
    chk("R2 one-shot single one-cycle pulse", 64'(pulses - base), 64'd1);
    chk("R2 pulse cycle after match", last_cnt, 64'd121);
  endtask

  task automatic t_periodic();
    int base;
    wcfg(4'd0);
    load(64'd1000);
    wcfg(PER | SETV);
    wlo(32'd1100);
    chk("R6 load bit cleared by write", {58'd0, cfg_rd}, 64'h32);
    wlo(32'd20);
    whi(32'd0);
    chk("R6 comparator kept without load bit", cmp_rd, 64'd1100);
    base = pulses;
    wcfg(PER | EN);
    wait_ctr(64'd1150);
    chk("R4 pulses per period", 64'(pulses - base), 64'd3);
    chk("R4 third pulse position", last_cnt, 64'd1141);
    chk("R4 comparator advanced", cmp_rd, 64'd1160);
  endtask

  task automatic t_catchup();
    int base;
    wcfg(4'd0);
    run = 1'b0;
    load(64'd5000);
    wcfg(PER | SETV);
    wlo(32'd1000); wlo(32'd1000); whi(32'd0);
    base = pulses;
    wcfg(PER | EN);
    repeat (10) @(negedge clk);
    chk("R11 no arm while counter stopped", 64'(pulses - base), 64'd0);
    run = 1'b1;
    wait_ctr(64'd5030);
    chk("R5 single pulse during catch-up", 64'(pulses - base), 64'd1);
    chk("R5 comparator ahead after catch-up", cmp_rd, 64'd6000);
  endtask

  task automatic t_narrow_trunc();
    wcfg(4'd0);
    whi(32'hAB); wlo(32'h50);
    chk("R8 wide comparator", cmp_rd, 64'h0000_00AB_0000_0050);
    wcfg(NAR);
    chk("R8 narrow truncates", cmp_rd, 64'h50);
    whi(32'h77);
    chk("R8 upper write ignored", cmp_rd, 64'h50);
  endtask

  task automatic t_narrow_periodic();
    int base;
    wcfg(NAR);
    load(64'h1_FFFF_FF00);
    wcfg(NAR | PER | SETV);
    wlo(32'hFFFF_FFF0);
    wlo(32'h8000_0020);
    base = pulses;
    wcfg(NAR | PER | EN);
    wait_ctr(64'h2_0000_0020);
    chk("R9 R7 R3 narrow periodic pulses", 64'(pulses - base), 64'd2);
    chk("R9 second pulse after 32-bit wrap", last_cnt, 64'h2_0000_0011);
    chk("R9 comparator wraps mod 2^32", cmp_rd, 64'h30);
  endtask

  task automatic t_wrap_event();
    int base;
    wcfg(NAR);
    load(64'hFFFF_FF00);
    wlo(32'h10);
    base = pulses;
    wcfg(NAR | EN);
    wait_ctr(64'h1_0000_0005);
    chk("R10 roll-over pulse count", 64'(pulses - base), 64'd1);
    chk("R10 roll-over pulse position", last_cnt, 64'h1_0000_0001);
    wait_ctr(64'h1_0000_0030);
    chk("R10 match pulse follows", 64'(pulses - base), 64'd2);
    chk("R10 match pulse position", last_cnt, 64'h1_0000_0011);
  endtask

  task automatic t_rearm();
    int base;
    wcfg(NAR);
    load(64'hFFFF_FF00);
    wlo(32'h10);
    base = pulses;
    wcfg(NAR | EN);
    wlo(32'hFFFF_FF80);
    wait_ctr(64'h1_0000_0030);
    chk("R11 re-arm drops pending wrap", 64'(pulses - base), 64'd1);
    chk("R11 pulse at new match", last_cnt, 64'hFFFF_FF81);
  endtask

  task automatic t_disarm();
    int base;
    wcfg(4'd0);
    load(64'd200);
    wlo(32'd260); whi(32'd0);
    base = pulses;
    wcfg(EN);
    wait_ctr(64'd230);
    wcfg(4'd0);
    wait_ctr(64'd300);
    chk("R12 disarmed channel silent", 64'(pulses - base), 64'd0);
  endtask

  task automatic t_zero_period();
    int base;
    wcfg(4'd0);
    load(64'd3000);
    wcfg(PER | SETV);
    wlo(32'd3050); wlo(32'd0); whi(32'd0);
    base = pulses;
    wcfg(PER | EN);
    wait_ctr(64'd3200);
    chk("R13 zero period fires once", 64'(pulses - base), 64'd1);
    chk("R13 pulse position", last_cnt, 64'd3051);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_oneshot();
    t_periodic();
    t_catchup();
    t_narrow_trunc();
    t_narrow_periodic();
    t_wrap_event();
    t_rearm();
    t_disarm();
    t_zero_period();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule